// File: doc/BRIEF.md
# Indirect Interrupt-Routing Register Window

This block is the software-visible register front end of an I/O interrupt router. Software does not address the routing state directly. It first writes a register number into a select register. It then reads or writes a 32-bit data window, and that access reaches whichever register the select value names. Behind the window sit four things: an identification register, a read-only version register, an arbitration register that mirrors the identification value, and a redirection table with one 64-bit entry per input pin. Each table entry is reached as two 32-bit halves.

The block stores the select register, the 4-bit identification value and the table. It drives every entry's decoded fields continuously to the delivery logic. When a write flips an entry's mask bit, it emits a one-cycle notice. It also emits a one-cycle notice for every accepted table write, and a service request when the rewritten pin already has its request bit raised. The servicing logic can set or clear an entry's remote-IRR bit through a dedicated input. Interrupt delivery and pin sampling belong to other blocks.

Top module: `irq_route_regs`

## Requirements
- R1: Select value 0x01 names the version register. A window read returns NPINS-1 in bits 23:16 and the constant VER_CODE (default 0x11) in bits 7:0, with all other bits zero. With 24 pins the word is 0x00170011. Window writes at this select change nothing.
- R2: Select value 0x00 names the identification register. A window write stores wdata[27:24], and a read returns that value in bits 27:24 with all other bits zero. Select value 0x02 reads back the same word. Window writes at select 0x02 leave the identification value unchanged.
- R3: A select value S of 0x10 or above reaches table entry (S-0x10)>>1. An odd S reaches the high word and an even S reaches the low word. Low word layout: vector[7:0], delivery mode[10:8], destination mode[11], bit 12 always zero, polarity[13], remote IRR[14], trigger mode[15], mask[16]. Bits 31:17 read zero. High word layout: destination in bits 31:24, all other bits read zero.
- R4: A write to an entry's low word forces that entry's remote-IRR bit to 0, whatever value wdata[14] carries. A write to the high word leaves remote IRR unchanged.
- R5: A table access whose computed index is NPINS or more is discarded: writes change no state and raise no notice, and reads return 0. Reads at select values 0x03 to 0x0F also return 0.
- R6: In the cycle after a low-word write that changes an entry's mask bit, mask_chg_vld is 1 for exactly one cycle, with mask_chg_idx set to the entry and mask_chg_val set to the new mask. If the mask bit does not change, no notice is raised.
- R7: In the cycle after every accepted table write, ent_wr_vld is 1 for one cycle with ent_wr_idx set to the entry. In that same cycle, svc_req_vld is 1 with svc_req_idx set to the entry when irr_in for that pin is 1.
- R8: Only addr[7:0] is decoded. Offset 0x00 holds the select register, which reads back zero-extended, and offset 0x10 is the data window. Reads of any other offset return 0, and writes to them have no effect. A write is accepted only when wr_bytes is 4 or 8.
- R9: A read issued with rd_en returns its data on rdata in the next cycle, with rvalid set to 1 for that cycle.
- R10: After reset, every entry's mask bit is 1, every other entry field is 0, and the select register and the identification value are 0.
- R11: When rirr_clr_vld is 1, the remote-IRR bit of entry rirr_idx is cleared on the next edge. Otherwise, when rirr_set_vld is 1, that bit is set. Clear takes priority over set.
- R12: The ent_* outputs always carry the stored fields of each entry, with pin i in slice i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Bus write strobe |
| rd_en | input | 1 | Bus read strobe |
| addr | input | ADDR_W | Byte address (low 8 bits decoded) |
| wr_bytes | input | 4 | Write size in bytes |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, one cycle after rd_en |
| rvalid | output | 1 | Read data valid |
| irr_in | input | NPINS | Per-pin pending request bits |
| rirr_set_vld | input | 1 | Set remote IRR of rirr_idx |
| rirr_clr_vld | input | 1 | Clear remote IRR of rirr_idx |
| rirr_idx | input | IDX_W | Entry addressed by the remote-IRR update |
| ent_vector | output | NPINS*8 | Vector field per pin |
| ent_dlv_mode | output | NPINS*3 | Delivery mode per pin |
| ent_dst_mode | output | NPINS | Destination mode per pin |
| ent_polarity | output | NPINS | Polarity per pin |
| ent_rirr | output | NPINS | Remote IRR per pin |
| ent_trig | output | NPINS | Trigger mode per pin |
| ent_mask | output | NPINS | Mask per pin |
| ent_dest | output | NPINS*8 | Destination per pin |
| mask_chg_vld | output | 1 | Mask-flip notice |
| mask_chg_idx | output | IDX_W | Entry whose mask flipped |
| mask_chg_val | output | 1 | New mask value |
| ent_wr_vld | output | 1 | Table entry rewritten |
| ent_wr_idx | output | IDX_W | Entry rewritten |
| svc_req_vld | output | 1 | Service request after rewrite |
| svc_req_idx | output | IDX_W | Pin to service |

## Verification
The embedded assertions hold on every cycle for the following behaviours. A mask notice always matches a real flip of the stored mask. A low-word write always leaves remote IRR clear. Table write strobes are never raised for more than one entry, nor for an out-of-range index. A service request never appears without an entry-write notice. Narrow writes never move the select register.

Some behaviours are shown only by the bench's directed scenarios. These are the exact read-back words of the version, identification and arbitration registers, the odd/even split of an entry into its two words, zero reads at unmapped selects and offsets, the set-versus-clear priority on remote IRR, and the reset contents.

// File: rtl/irp_pkg.sv
package irp_pkg;

  typedef struct packed {
    logic [7:0] dest;
    logic       mask;
    logic       trig;
    logic       rirr;
    logic       pol;
    logic       dst_mode;
    logic [2:0] dlv_mode;
    logic [7:0] vector;
  } irp_ent_t;

  localparam logic [7:0] SEL_ID   = 8'h00;
  localparam logic [7:0] SEL_VER  = 8'h01;
  localparam logic [7:0] SEL_ARB  = 8'h02;
  localparam logic [7:0] SEL_TBL0 = 8'h10;
  localparam logic [7:0] OFF_SEL  = 8'h00;
  localparam logic [7:0] OFF_WIN  = 8'h10;

  // Entry number reached by a table select value.
  function automatic logic [6:0] sel_to_idx(input logic [7:0] sel);
    logic [7:0] diff;
    diff = sel - SEL_TBL0;
    return diff[7:1];
  endfunction

  function automatic logic [31:0] version_word(input int npins, input logic [7:0] code);
    logic [7:0] top;
    top = 8'(npins - 1);
    return {8'h00, top, 8'h00, code};
  endfunction

  function automatic logic [31:0] pack_lo(input irp_ent_t e);
    return {15'd0, e.mask, e.trig, e.rirr, e.pol, 1'b0, e.dst_mode, e.dlv_mode, e.vector};
  endfunction

  function automatic logic [31:0] pack_hi(input irp_ent_t e);
    return {e.dest, 24'd0};
  endfunction

  function automatic logic size_ok(input logic [3:0] nbytes);
    return (nbytes == 4'd4) || (nbytes == 4'd8);
  endfunction

endpackage

// File: rtl/irp_sel_decode.sv
module irp_sel_decode
  import irp_pkg::*;
#(
  parameter int NPINS = 24,
  localparam int IDX_W = $clog2(NPINS)
) (
  input  logic [7:0]       sel,
  output logic             is_id,
  output logic             is_ver,
  output logic             is_arb,
  output logic             tbl_hit,
  output logic             hi_half,
  output logic [IDX_W-1:0] idx
);
  logic [6:0] raw_idx;
  logic       is_tbl;

  always_comb begin
    raw_idx = sel_to_idx(sel);
    is_id   = (sel == SEL_ID);
    is_ver  = (sel == SEL_VER);
    is_arb  = (sel == SEL_ARB);
    is_tbl  = (sel >= SEL_TBL0);
    tbl_hit = is_tbl && (32'(raw_idx) < NPINS);
    hi_half = sel[0];
    idx     = raw_idx[IDX_W-1:0];
  end
endmodule

// File: rtl/irp_entry.sv
module irp_entry
  import irp_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_lo,
  input  logic        wr_hi,
  input  logic [31:0] wdata,
  input  logic        rirr_set,
  input  logic        rirr_clr,
  output irp_ent_t    ent
);
  irp_ent_t ent_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ent_q      <= '0;
      ent_q.mask <= 1'b1;
    end else begin
      if (wr_lo) begin
        ent_q.vector   <= wdata[7:0];
        ent_q.dlv_mode <= wdata[10:8];
        ent_q.dst_mode <= wdata[11];
        ent_q.pol      <= wdata[13];
        ent_q.trig     <= wdata[15];
        ent_q.mask     <= wdata[16];
      end
      if (wr_hi) ent_q.dest <= wdata[31:24];
      if (wr_lo || rirr_clr) ent_q.rirr <= 1'b0;
      else if (rirr_set)     ent_q.rirr <= 1'b1;
    end
  end

  assign ent = ent_q;

  AST_LOW_WR_CLEARS_RIRR: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lo |=> !ent_q.rirr); // R4
  AST_HI_WR_KEEPS_RIRR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hi && !wr_lo && !rirr_clr && !rirr_set) |=> $stable(ent_q.rirr)); // R4
  AST_RIRR_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (rirr_clr && rirr_set) |=> !ent_q.rirr); // R11
endmodule

// File: rtl/irp_rdmux.sv
module irp_rdmux
  import irp_pkg::*;
#(
  parameter int         NPINS    = 24,
  parameter logic [7:0] VER_CODE = 8'h11,
  localparam int IDX_W = $clog2(NPINS)
) (
  input  logic             is_id,
  input  logic             is_ver,
  input  logic             is_arb,
  input  logic             tbl_hit,
  input  logic             hi_half,
  input  logic [IDX_W-1:0] idx,
  input  logic [3:0]       id_val,
  input  irp_ent_t         ents [NPINS],
  output logic [31:0]      win_word
);
  irp_ent_t sel_ent;

  always_comb begin
    sel_ent = '0;
    for (int i = 0; i < NPINS; i++)
      if (idx == IDX_W'(i)) sel_ent = ents[i];
  end

  always_comb begin
    if (is_ver)                 win_word = version_word(NPINS, VER_CODE);
    else if (is_id || is_arb)   win_word = {4'd0, id_val, 24'd0};
    else if (tbl_hit)           win_word = hi_half ? pack_hi(sel_ent) : pack_lo(sel_ent);
    else                        win_word = 32'd0;
  end
endmodule

// File: rtl/irq_route_regs.sv
module irq_route_regs
  import irp_pkg::*;
#(
  parameter int         NPINS    = 24,
  parameter int         ADDR_W   = 12,
  parameter logic [7:0] VER_CODE = 8'h11,
  localparam int IDX_W = $clog2(NPINS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic                 rd_en,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [3:0]           wr_bytes,
  input  logic [31:0]          wdata,
  output logic [31:0]          rdata,
  output logic                 rvalid,
  input  logic [NPINS-1:0]     irr_in,
  input  logic                 rirr_set_vld,
  input  logic                 rirr_clr_vld,
  input  logic [IDX_W-1:0]     rirr_idx,
  output logic [NPINS*8-1:0]   ent_vector,
  output logic [NPINS*3-1:0]   ent_dlv_mode,
  output logic [NPINS-1:0]     ent_dst_mode,
  output logic [NPINS-1:0]     ent_polarity,
  output logic [NPINS-1:0]     ent_rirr,
  output logic [NPINS-1:0]     ent_trig,
  output logic [NPINS-1:0]     ent_mask,
  output logic [NPINS*8-1:0]   ent_dest,
  output logic                 mask_chg_vld,
  output logic [IDX_W-1:0]     mask_chg_idx,
  output logic                 mask_chg_val,
  output logic                 ent_wr_vld,
  output logic [IDX_W-1:0]     ent_wr_idx,
  output logic                 svc_req_vld,
  output logic [IDX_W-1:0]     svc_req_idx
);
  // Bus decode (named for the assertions)
  logic [7:0] off;
  logic       wr_accept;
  logic       sel_wr;
  logic       win_wr;
  logic       narrow_wr;

  assign off       = addr[7:0];
  assign wr_accept = wr_en && size_ok(wr_bytes);
  assign narrow_wr = wr_en && !size_ok(wr_bytes);
  assign sel_wr    = wr_accept && (off == OFF_SEL);
  assign win_wr    = wr_accept && (off == OFF_WIN);

  logic [7:0] sel_q;
  logic [3:0] id_q;

  logic             is_id, is_ver, is_arb, tbl_hit, hi_half;
  logic [IDX_W-1:0] idx;

  irp_sel_decode #(.NPINS(NPINS)) u_dec (
    .sel(sel_q), .is_id(is_id), .is_ver(is_ver), .is_arb(is_arb),
    .tbl_hit(tbl_hit), .hi_half(hi_half), .idx(idx)
  );

  logic             tbl_wr;
  logic [NPINS-1:0] wr_lo_vec;
  logic [NPINS-1:0] wr_hi_vec;
  irp_ent_t         ents [NPINS];
  logic [NPINS-1:0] mask_vec;

  assign tbl_wr = win_wr && tbl_hit;

  for (genvar g = 0; g < NPINS; g++) begin : g_ent
    logic hit;
    assign hit          = tbl_wr && (idx == IDX_W'(g));
    assign wr_lo_vec[g] = hit && !hi_half;
    assign wr_hi_vec[g] = hit && hi_half;

    irp_entry u_ent (
      .clk(clk), .rst_n(rst_n),
      .wr_lo(wr_lo_vec[g]), .wr_hi(wr_hi_vec[g]), .wdata(wdata),
      .rirr_set(rirr_set_vld && (rirr_idx == IDX_W'(g))),
      .rirr_clr(rirr_clr_vld && (rirr_idx == IDX_W'(g))),
      .ent(ents[g])
    );

    assign ent_vector[g*8 +: 8]   = ents[g].vector;
    assign ent_dlv_mode[g*3 +: 3] = ents[g].dlv_mode;
    assign ent_dst_mode[g]        = ents[g].dst_mode;
    assign ent_polarity[g]        = ents[g].pol;
    assign ent_rirr[g]            = ents[g].rirr;
    assign ent_trig[g]            = ents[g].trig;
    assign ent_mask[g]            = ents[g].mask;
    assign ent_dest[g*8 +: 8]     = ents[g].dest;
    assign mask_vec[g]            = ents[g].mask;
  end

  // Select and identification registers
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q <= '0;
      id_q  <= '0;
    end else begin
      if (sel_wr)          sel_q <= wdata[7:0];
      if (win_wr && is_id) id_q  <= wdata[27:24];
    end
  end

  // Notices
  logic cur_mask;
  logic mask_flip;
  always_comb begin
    cur_mask = 1'b0;
    for (int i = 0; i < NPINS; i++)
      if (idx == IDX_W'(i)) cur_mask = mask_vec[i];
  end
  assign mask_flip = tbl_wr && !hi_half && (wdata[16] != cur_mask);

  logic pin_pending;
  always_comb begin
    pin_pending = 1'b0;
    for (int i = 0; i < NPINS; i++)
      if (idx == IDX_W'(i)) pin_pending = irr_in[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_chg_vld <= 1'b0;
      mask_chg_idx <= '0;
      mask_chg_val <= 1'b0;
      ent_wr_vld   <= 1'b0;
      ent_wr_idx   <= '0;
      svc_req_vld  <= 1'b0;
      svc_req_idx  <= '0;
    end else begin
      mask_chg_vld <= mask_flip;
      ent_wr_vld   <= tbl_wr;
      svc_req_vld  <= tbl_wr && pin_pending;
      if (mask_flip) begin
        mask_chg_idx <= idx;
        mask_chg_val <= wdata[16];
      end
      if (tbl_wr) begin
        ent_wr_idx  <= idx;
        svc_req_idx <= idx;
      end
    end
  end

  // Read path
  logic [31:0] win_word;
  irp_rdmux #(.NPINS(NPINS), .VER_CODE(VER_CODE)) u_rd (
    .is_id(is_id), .is_ver(is_ver), .is_arb(is_arb), .tbl_hit(tbl_hit),
    .hi_half(hi_half), .idx(idx), .id_val(id_q), .ents(ents), .win_word(win_word)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= rd_en;
      if (rd_en) begin
        if (off == OFF_SEL)      rdata <= {24'd0, sel_q};
        else if (off == OFF_WIN) rdata <= win_word;
        else                     rdata <= 32'd0;
      end
    end
  end

  // Assertions
  AST_MASK_NOTE_MATCHES: assert property (@(posedge clk) disable iff (!rst_n)
    mask_chg_vld |-> (mask_vec[mask_chg_idx] == mask_chg_val)); // R6
  AST_MASK_NOTE_REAL_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    mask_chg_vld |-> ($past(mask_vec) != mask_vec)); // R6
  AST_MASK_NOTE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_chg_vld && !mask_flip) |=> !mask_chg_vld); // R6
  AST_ONE_ENTRY_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_lo_vec | wr_hi_vec)); // R3
  AST_NO_OOR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    ent_wr_vld |-> (32'(ent_wr_idx) < NPINS)); // R5
  AST_SVC_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    svc_req_vld |-> (ent_wr_vld && svc_req_idx == ent_wr_idx)); // R7
  AST_NARROW_KEEPS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    narrow_wr |=> $stable(sel_q)); // R8
  AST_RVALID_FOLLOWS_RD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rvalid); // R9
endmodule

// File: tb/test_irq_route_regs.sv
module test_irq_route_regs;
  localparam int NPINS = 24;
  localparam int IDX_W = $clog2(NPINS);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [11:0] addr = '0;
  logic [3:0] wr_bytes = 4'd4;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic rvalid;
  logic [NPINS-1:0] irr_in = '0;
  logic rirr_set_vld = 1'b0, rirr_clr_vld = 1'b0;
  logic [IDX_W-1:0] rirr_idx = '0;
  logic [NPINS*8-1:0] ent_vector, ent_dest;
  logic [NPINS*3-1:0] ent_dlv_mode;
  logic [NPINS-1:0] ent_dst_mode, ent_polarity, ent_rirr, ent_trig, ent_mask;
  logic mask_chg_vld, mask_chg_val, ent_wr_vld, svc_req_vld;
  logic [IDX_W-1:0] mask_chg_idx, ent_wr_idx, svc_req_idx;

  int checks = 0;
  int fails = 0;

  // Notices seen in the cycle after the last write
  logic n_mask_vld, n_mask_val, n_wr_vld, n_svc_vld;
  logic [IDX_W-1:0] n_mask_idx, n_wr_idx, n_svc_idx;

  always #5 clk = ~clk;

  irq_route_regs i_irq_route_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wr_bytes(wr_bytes), .wdata(wdata), .rdata(rdata), .rvalid(rvalid),
    .irr_in(irr_in), .rirr_set_vld(rirr_set_vld), .rirr_clr_vld(rirr_clr_vld),
    .rirr_idx(rirr_idx), .ent_vector(ent_vector), .ent_dlv_mode(ent_dlv_mode),
    .ent_dst_mode(ent_dst_mode), .ent_polarity(ent_polarity), .ent_rirr(ent_rirr),
    .ent_trig(ent_trig), .ent_mask(ent_mask), .ent_dest(ent_dest),
    .mask_chg_vld(mask_chg_vld), .mask_chg_idx(mask_chg_idx), .mask_chg_val(mask_chg_val),
    .ent_wr_vld(ent_wr_vld), .ent_wr_idx(ent_wr_idx),
    .svc_req_vld(svc_req_vld), .svc_req_idx(svc_req_idx)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] nb);
    @(negedge clk);
    wr_en = 1'b1; addr = {4'h0, a}; wdata = d; wr_bytes = nb;
    @(negedge clk);
    wr_en = 1'b0; wr_bytes = 4'd4;
    n_mask_vld = mask_chg_vld; n_mask_idx = mask_chg_idx; n_mask_val = mask_chg_val;
    n_wr_vld = ent_wr_vld; n_wr_idx = ent_wr_idx;
    n_svc_vld = svc_req_vld; n_svc_idx = svc_req_idx;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = {4'h0, a};
    @(negedge clk);
    rd_en = 1'b0;
    checks++;
    if (rvalid !== 1'b1) begin
      fails++;
      $display("FAIL R9 rvalid actual=%b expected=1", rvalid);
    end
    d = rdata;
  endtask

  task automatic win_rd(input logic [7:0] s, output logic [31:0] d);
    bus_wr(8'h00, {24'd0, s}, 4'd4);
    bus_rd(8'h10, d);
  endtask

  task automatic win_wr(input logic [7:0] s, input logic [31:0] v);
    bus_wr(8'h00, {24'd0, s}, 4'd4);
    bus_wr(8'h10, v, 4'd4);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R10 mask all set", 32'(ent_mask), 32'(24'hFFFFFF));
    chk("R10 rirr clear", 32'(ent_rirr), 32'd0);
    chk("R10 vectors zero", 32'(ent_vector[31:0]), 32'd0);
    bus_rd(8'h00, d);       chk("R10 select zero", d, 32'd0);
    bus_rd(8'h10, d);       chk("R10 id zero", d, 32'd0);
    win_rd(8'h10, d);       chk("R10 entry0 low", d, 32'h0001_0000);
    win_rd(8'h3F, d);       chk("R10 entry23 high", d, 32'd0);
  endtask

  task automatic t_version();
    logic [31:0] d;
    win_rd(8'h01, d);       chk("R1 version word", d, 32'h0017_0011);
    bus_wr(8'h10, 32'hFFFF_FFFF, 4'd4);
    bus_rd(8'h10, d);       chk("R1 version write ignored", d, 32'h0017_0011);
  endtask

  task automatic t_id();
    logic [31:0] d;
    win_wr(8'h00, 32'hA5FF_FFFF);
    bus_rd(8'h10, d);       chk("R2 id readback", d, 32'h0500_0000);
    win_rd(8'h02, d);       chk("R2 arb mirrors id", d, 32'h0500_0000);
    bus_wr(8'h10, 32'h0F00_0000, 4'd4);
    win_rd(8'h00, d);       chk("R2 arb write ignored", d, 32'h0500_0000);
  endtask

  task automatic t_table();
    logic [31:0] d;
    win_wr(8'h16, 32'hFFFF_FFFF);  // entry 3 low
    chk("R6 no notice without flip", 32'(n_mask_vld), 32'd0);
    chk("R7 write notice", {31'd0, n_wr_vld}, 32'd1);
    chk("R7 write idx", 32'(n_wr_idx), 32'd3);
    bus_rd(8'h10, d);       chk("R3 R4 entry3 low", d, 32'h0001_AFFF);
    win_wr(8'h16, 32'h0000_0030);
    chk("R6 mask notice", {31'd0, n_mask_vld}, 32'd1);
    chk("R6 mask idx", 32'(n_mask_idx), 32'd3);
    chk("R6 mask val", {31'd0, n_mask_val}, 32'd0);
    win_wr(8'h17, 32'hFFFF_FFFF);  // entry 3 high
    bus_rd(8'h10, d);       chk("R3 entry3 high", d, 32'hFF00_0000);
    win_rd(8'h16, d);       chk("R3 low intact after high", d, 32'h0000_0030);
    chk("R12 vector out", 32'(ent_vector[3*8 +: 8]), 32'h30);
    chk("R12 dest out", 32'(ent_dest[3*8 +: 8]), 32'hFF);
    chk("R12 mask out", 32'(ent_mask[3]), 32'd0);
    win_wr(8'h3E, 32'h0001_0042);   // entry 23, last
    bus_rd(8'h10, d);       chk("R3 last entry", d, 32'h0001_0042);
  endtask

  task automatic t_range();
    logic [31:0] d;
    win_wr(8'h40, 32'h0000_0055);
    chk("R5 oor no notice", 32'(n_wr_vld), 32'd0);
    bus_rd(8'h10, d);       chk("R5 oor read zero", d, 32'd0);
    win_rd(8'h05, d);       chk("R5 gap select zero", d, 32'd0);
    chk("R5 entry0 untouched", 32'(ent_vector[7:0]), 32'd0);
  endtask

  task automatic t_rirr();
    logic [31:0] d;
    @(negedge clk); rirr_set_vld = 1'b1; rirr_idx = 5'd5;
    @(negedge clk); rirr_set_vld = 1'b0;
    win_rd(8'h1A, d);       chk("R11 rirr set", d, 32'h0001_4000);
    win_wr(8'h1B, 32'h1200_0000);
    chk("R4 high keeps rirr", 32'(ent_rirr[5]), 32'd1);
    win_wr(8'h1A, 32'h0001_4041);
    bus_rd(8'h10, d);       chk("R4 low clears rirr", d, 32'h0001_0041);
    @(negedge clk); rirr_set_vld = 1'b1; rirr_idx = 5'd5;
    @(negedge clk); rirr_set_vld = 1'b1; rirr_clr_vld = 1'b1;
    @(negedge clk); rirr_set_vld = 1'b0; rirr_clr_vld = 1'b0;
    chk("R11 clear wins", 32'(ent_rirr[5]), 32'd0);
  endtask

  task automatic t_service();
    irr_in = '0; irr_in[7] = 1'b1;
    win_wr(8'h1E, 32'h0001_0000);
    chk("R7 svc raised", {31'd0, n_svc_vld}, 32'd1);
    chk("R7 svc idx", 32'(n_svc_idx), 32'd7);
    win_wr(8'h20, 32'h0001_0000);
    chk("R7 no svc idle pin", 32'(n_svc_vld), 32'd0);
    chk("R7 write notice pin8", 32'(n_wr_idx), 32'd8);
    irr_in = '0;
  endtask

  task automatic t_decode();
    logic [31:0] d;
    bus_wr(8'h00, 32'h0000_0012, 4'd4);
    bus_wr(8'h00, 32'h0000_0077, 4'd2);
    bus_rd(8'h00, d);       chk("R8 narrow write rejected", d, 32'h12);
    bus_wr(8'h00, 32'h0000_0014, 4'd8);
    bus_rd(8'h00, d);       chk("R8 8-byte write accepted", d, 32'h14);
    bus_wr(8'h20, 32'h0000_0099, 4'd4);
    bus_rd(8'h00, d);       chk("R8 undecoded write ignored", d, 32'h14);
    bus_rd(8'h20, d);       chk("R8 undecoded read zero", d, 32'd0);
    @(negedge clk); wr_en = 1'b1; addr = 12'h300; wdata = 32'h16; wr_bytes = 4'd4;
    @(negedge clk); wr_en = 1'b0;
    bus_rd(8'h00, d);       chk("R8 high addr bits ignored", d, 32'h16);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_version();
    t_id();
    t_table();
    t_range();
    t_rirr();
    t_service();
    t_decode();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule